// File: doc/BRIEF.md
# Remote Flash Page Program Controller

This controller writes one flash page of a halted debug target without driving the flash itself. The page image must already be staged in target data RAM at 0xF000, in a buffer of up to 0x800 bytes that software may wipe to 0xFF beforehand. On a start strobe the controller first checks the page address and the detected flash word size. It then uses a command sequencer to copy a small constant stub routine into target RAM just above the staging buffer, at 0xF800. Two stub bytes are patched on the fly. Finally it points the target PC at the stub, lets the target run, and polls the target's status until the CPU reports halted.

Requests leave the block on a valid/ready stream. The block holds a request, with its operation, address and data, stable from the cycle `req_valid` rises until the sequencer takes it with `req_ready`. The sequencer may apply back-pressure for any number of cycles. Only a read-status request expects an answer. That answer comes back on `rsp_valid`/`rsp_data`, and the controller always accepts it. The sequencer turns a set-PC request into the 3-byte jump injection 0x02, high, low.

Top module: `flash_page_prog`

## Requirements
- R1: A start with a page address whose low 10 bits are not all zero ends one cycle later with `done` and `error` both high, and no request is issued.
- R2: A start with a word size other than 2 or 4 ends one cycle later with `done` and `error` both high, and no request is issued.
- R3: An accepted start first issues STUB_LEN write requests, op code 0, to addresses 0xF800+k in ascending k. The unpatched byte at offset k is (k*0x2F + 0x47) mod 256, so the placeholder at offset 25 is 0xDE.
- R4: The byte written at stub offset 2 is ((page_address >> 8) / word_size) & 0x7E.
- R5: The byte written at stub offset 25 is the word size.
- R6: After the upload, exactly one set-PC request (op code 1, address 0xF800) is issued, followed by exactly one resume request (op code 2).
- R7: The controller then issues read-status requests (op code 3), one at a time, and each waits for its response. A response with bit 7 set ends the operation with `done` high and `error` low.
- R8: If MAX_POLLS responses in a row come back without bit 7 set, the operation ends with `done` and `error` high, and no further request is issued.
- R9: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_op`, `req_addr` and `req_data` stay unchanged in the next cycle.
- R10: `busy` is high from the cycle after an accepted start until `done` pulses. A start while busy is ignored, and page address and word size are latched at the accepted start.
- R11: `done` is a single-cycle pulse, and `error` is high only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin programming one page |
| page_addr | input | ADDR_W | Flash byte address of the page |
| word_size | input | 3 | Detected flash word size in bytes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| error | output | 1 | Operation failed; valid with done |
| req_valid | output | 1 | Sequencer request present |
| req_ready | input | 1 | Sequencer takes the request |
| req_op | output | 2 | 0 write data byte, 1 set PC, 2 resume, 3 read status |
| req_addr | output | 16 | Target data address or new PC |
| req_data | output | 8 | Byte to write |
| rsp_valid | input | 1 | Status byte returned |
| rsp_data | input | 8 | Target status byte |

## Verification
The bench builds the block with a 17-bit page address, the default 40-byte stub, and MAX_POLLS set to 4. A 17-bit address has 128 aligned pages, so every one of them can be programmed with both legal word sizes, and every stub byte can be compared against its computed value. A short poll limit lets the halt position be swept through every count up to and past the timeout. Back-pressure follows a repeating pattern, so each request type is stalled at least once. The bench also covers each misaligned address bit, every illegal word size, and a start strobe issued during an upload.

// File: rtl/fpp_pkg.sv
package fpp_pkg;
  typedef enum logic [1:0] {
    OP_XWRITE = 2'd0,
    OP_SETPC  = 2'd1,
    OP_RESUME = 2'd2,
    OP_STATUS = 2'd3
  } fpp_op_e;

  localparam int PATCH_HI_OFS = 2;
  localparam int PATCH_WS_OFS = 25;

  // Constant stub image, generated arithmetically; offset 25 yields 0xDE.
  function automatic logic [7:0] stub_base_byte(input int k);
    return 8'((k * 47 + 71) & 255);
  endfunction
endpackage

// File: rtl/fpp_param_check.sv
module fpp_param_check #(
  parameter int ADDR_W     = 17,
  parameter int ALIGN_LOG2 = 10
) (
  input  logic [ADDR_W-1:0] page_addr,
  input  logic [2:0]        word_size,
  output logic              params_ok,
  output logic [7:0]        hi_patch
);
  logic ws_legal;
  logic aligned;

  always_comb begin
    ws_legal  = (word_size == 3'd2) || (word_size == 3'd4);
    aligned   = (page_addr[ALIGN_LOG2-1:0] == '0);
    params_ok = ws_legal && aligned;
    // divide the page number by the word size: one extra shift for 4 bytes
    hi_patch  = 8'(page_addr >> ((word_size == 3'd4) ? 10 : 9)) & 8'h7E;
  end
endmodule

// File: rtl/fpp_stub_gen.sv
module fpp_stub_gen
  import fpp_pkg::*;
#(
  parameter int STUB_LEN = 40,
  localparam int IDX_W   = $clog2(STUB_LEN)
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       hi_patch,
  input  logic [2:0]       word_size,
  output logic [7:0]       stub_byte
);
  always_comb begin
    if (int'(idx) == PATCH_HI_OFS)
      stub_byte = hi_patch;
    else if (int'(idx) == PATCH_WS_OFS)
      stub_byte = {5'b0, word_size};
    else
      stub_byte = stub_base_byte(int'(idx));
  end
endmodule

// File: rtl/fpp_poll_timer.sv
module fpp_poll_timer #(
  parameter int MAX_POLLS = 1000,
  localparam int CNT_W    = $clog2(MAX_POLLS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt <= '0;
    else if (tick && !last) cnt <= cnt + 1'b1;
  end

  assign last = (cnt == CNT_W'(MAX_POLLS - 1));

  a_r8_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(MAX_POLLS));
endmodule

// File: rtl/flash_page_prog.sv
module flash_page_prog
  import fpp_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int ALIGN_LOG2 = 10,
  parameter int BUF_BASE   = 16'hF000,
  parameter int PAGE_MAX   = 16'h0800,
  parameter int STUB_LEN   = 40,
  parameter int MAX_POLLS  = 1000,
  parameter int HALT_BIT   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] page_addr,
  input  logic [2:0]        word_size,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [1:0]        req_op,
  output logic [15:0]       req_addr,
  output logic [7:0]        req_data,
  input  logic              rsp_valid,
  input  logic [7:0]        rsp_data
);
  localparam int          IDX_W     = $clog2(STUB_LEN);
  localparam logic [15:0] STUB_BASE = 16'(BUF_BASE + PAGE_MAX);

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_SETPC, S_RESUME, S_POLL, S_WAIT
  } state_e;

  state_e           state;
  logic [IDX_W-1:0] idx;
  logic [2:0]       ws_q;
  logic [7:0]       hi_q;
  logic             done_q, error_q;
  logic             params_ok;
  logic [7:0]       hi_patch;
  logic [7:0]       stub_byte;
  logic             poll_last;
  logic             fire, accept, halted, miss;

  fpp_param_check #(.ADDR_W(ADDR_W), .ALIGN_LOG2(ALIGN_LOG2)) u_check (
    .page_addr(page_addr), .word_size(word_size),
    .params_ok(params_ok), .hi_patch(hi_patch)
  );

  fpp_stub_gen #(.STUB_LEN(STUB_LEN)) u_stub (
    .idx(idx), .hi_patch(hi_q), .word_size(ws_q), .stub_byte(stub_byte)
  );

  assign accept = (state == S_IDLE) && start && params_ok;
  assign halted = rsp_data[HALT_BIT];
  assign miss   = (state == S_WAIT) && rsp_valid && !halted;

  fpp_poll_timer #(.MAX_POLLS(MAX_POLLS)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(accept), .tick(miss), .last(poll_last)
  );

  assign fire = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      idx     <= '0;
      ws_q    <= '0;
      hi_q    <= '0;
      done_q  <= 1'b0;
      error_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      error_q <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          if (params_ok) begin
            ws_q  <= word_size;
            hi_q  <= hi_patch;
            idx   <= '0;
            state <= S_LOAD;
          end else begin
            done_q  <= 1'b1;
            error_q <= 1'b1;
          end
        end
        S_LOAD: if (fire) begin
          if (idx == IDX_W'(STUB_LEN - 1)) state <= S_SETPC;
          else idx <= idx + 1'b1;
        end
        S_SETPC:  if (fire) state <= S_RESUME;
        S_RESUME: if (fire) state <= S_POLL;
        S_POLL:   if (fire) state <= S_WAIT;
        S_WAIT: if (rsp_valid) begin
          if (halted) begin
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else if (poll_last) begin
            done_q  <= 1'b1;
            error_q <= 1'b1;
            state   <= S_IDLE;
          end else begin
            state <= S_POLL;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    req_valid = 1'b0;
    req_op    = OP_XWRITE;
    req_addr  = '0;
    req_data  = '0;
    unique case (state)
      S_LOAD: begin
        req_valid = 1'b1;
        req_addr  = STUB_BASE + 16'(idx);
        req_data  = stub_byte;
      end
      S_SETPC: begin
        req_valid = 1'b1;
        req_op    = OP_SETPC;
        req_addr  = STUB_BASE;
      end
      S_RESUME: begin
        req_valid = 1'b1;
        req_op    = OP_RESUME;
      end
      S_POLL: begin
        req_valid = 1'b1;
        req_op    = OP_STATUS;
      end
      default: ;
    endcase
  end

  assign busy  = (state != S_IDLE);
  assign done  = done_q;
  assign error = error_q;

  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_op) &&
                                $stable(req_addr) && $stable(req_data));
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_error_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);
  a_r1_misaligned_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && (page_addr[ALIGN_LOG2-1:0] != '0) |=> done && error && !busy);
  a_r2_bad_ws_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && !(word_size == 3'd2 || word_size == 3'd4) |=> done && error);
  a_r10_req_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy);
  a_r7_rsp_known: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !$isunknown(rsp_data));
endmodule

// File: tb/test_flash_page_prog.sv
module test_flash_page_prog;
  localparam int AW = 17;
  localparam int SL = 40;
  localparam int MP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] page_addr = '0;
  logic [2:0]    word_size = '0;
  logic          busy, done, error;
  logic          req_valid, req_ready = 1'b0;
  logic [1:0]    req_op;
  logic [15:0]   req_addr;
  logic [7:0]    req_data;
  logic          rsp_valid = 1'b0;
  logic [7:0]    rsp_data = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  flash_page_prog #(.ADDR_W(AW), .STUB_LEN(SL), .MAX_POLLS(MP)) i_flash_page_prog (
    .clk(clk), .rst_n(rst_n), .start(start), .page_addr(page_addr),
    .word_size(word_size), .busy(busy), .done(done), .error(error),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_byte(input int k, input int a, input int ws);
    if (k == 2)  return ((a >> 8) / ws) & 8'h7E;
    if (k == 25) return ws;
    return (k * 47 + 71) & 255;
  endfunction

  task automatic run_page(input int a, input int ws, input int halt_after, input bit poke);
    bit ok = ((a & 10'h3FF) == 0) && (ws == 2 || ws == 4);
    int nreq = 0, polls = 0, cyc = 0;
    bit pend = 0, fin = 0, stalled = 0;
    logic [1:0] s_op; logic [15:0] s_addr; logic [7:0] s_data;
    bit exp_err = !ok || (halt_after >= MP);
    int exp_polls = (halt_after + 1 < MP) ? halt_after + 1 : MP;
    @(negedge clk);
    page_addr = AW'(a); word_size = 3'(ws); start = 1'b1;
    @(negedge clk);
    start = 1'b0; page_addr = ~AW'(a); word_size = 3'd3;
    while (!fin && cyc < 2000) begin
      rsp_valid = 1'b0;
      if (stalled) begin
        chk(req_valid && req_op == s_op && req_addr == s_addr && req_data == s_data,
            "R9 stalled request held", int'(req_addr), int'(s_addr));
        stalled = 0;
      end
      if (done) begin
        chk(error == exp_err, "R11 error flag at done", int'(error), int'(exp_err));
        chk(!busy, "R10 busy cleared at done", int'(busy), 0);
        if (!ok) begin
          chk(nreq == 0 && cyc == 0, "R1 R2 immediate abort", nreq, 0);
        end else begin
          chk(polls == exp_polls, exp_err ? "R8 timeout poll count" : "R7 poll count",
              polls, exp_polls);
          chk(nreq == SL + 2 + polls, "R6 request count", nreq, SL + 2 + polls);
        end
        fin = 1;
      end else begin
        if (!busy || req_valid) chk(busy, "R10 busy during operation", int'(busy), 1);
        if (pend) begin
          rsp_valid = 1'b1;
          rsp_data = (polls > halt_after) ? 8'(8'h80 | (polls * 5)) : 8'(8'h7F & (polls * 13));
          pend = 0;
        end
        if (poke && cyc == 5) begin
          start = 1'b1; page_addr = AW'(17'h00C00); word_size = 3'd2;
        end else begin
          start = 1'b0;
        end
        req_ready = (cyc % 3 != 2);
        if (req_valid && !req_ready) begin
          stalled = 1; s_op = req_op; s_addr = req_addr; s_data = req_data;
        end
        if (req_valid && req_ready) begin
          if (nreq < SL) begin
            int eb = exp_byte(nreq, a, ws);
            chk(req_op == 2'd0 && req_addr == 16'(16'hF800 + nreq),
                "R3 upload address", int'(req_addr), 16'hF800 + nreq);
            chk(req_data == 8'(eb), nreq == 2 ? "R4 page patch byte" :
                (nreq == 25 ? "R5 word size patch" : "R3 stub byte"), int'(req_data), eb);
          end else if (nreq == SL) begin
            chk(req_op == 2'd1 && req_addr == 16'hF800, "R6 set PC", int'(req_addr), 16'hF800);
          end else if (nreq == SL + 1) begin
            chk(req_op == 2'd2, "R6 resume", int'(req_op), 2);
          end else begin
            chk(req_op == 2'd3, "R7 status poll op", int'(req_op), 3);
            polls++; pend = 1;
          end
          nreq++;
        end
        @(negedge clk);
        cyc++;
      end
    end
    chk(fin, "R11 operation finished", cyc, 0);
    req_ready = 1'b0; start = 1'b0; rsp_valid = 1'b0;
    @(negedge clk);
    chk(!done && !error, "R11 done single pulse", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !error && !req_valid, "R10 R11 reset state", int'(busy), 0);
    for (int p = 0; p < 128; p++)
      for (int w = 2; w <= 4; w += 2)
        run_page(p * 16'h400, w, p % 3, p == 5);
    for (int b = 0; b < 10; b++) run_page((1 << b) | 16'h800, 2, 0, 0);
    for (int w = 0; w < 8; w++)
      if (w != 2 && w != 4) run_page(16'h1C00, w, 0, 0);
    for (int h = 0; h <= MP + 1; h++) run_page(17'h1FC00, 4, h, 0);
    run_page(16'h400, 2, MP + 3, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule